// File: doc/BRIEF.md
# Requester-Aware Memory-Map Decoder

This block classifies a 32-bit physical address as DDR, on-chip RAM or unmapped, and returns the offset inside the selected memory. The answer depends on a small set of programmable registers and on the kind of requester that issued the access. A requester is either the processor or its coherent port, or a high-performance fabric port. The same address can therefore reach different memories, or no memory, depending on who asks.

The on-chip RAM is 256 kB in four 64 kB quarters. Each quarter sits either in a high window at the top of the address space or in a low window at the bottom. A snoop unit with an address filter, set with 1 MB granularity, decides how the lowest megabyte behaves. Software programs four registers through a write-only port. A lookup is presented with a valid strobe, and the registered answer appears one clock later.

Top module: `mem_map_decoder`

## Requirements
- R1: A lookup with `lk_valid` high produces `res_valid` high on the next clock, with the result for that lookup. `res_valid` is low in the cycle after any cycle without a lookup, and it is low during reset.
- R2: After reset the decoder behaves as follows: all four quarters are placed high, the snoop unit is enabled, filtering is enabled, the filter start is 0x0000_0000 and the filter end is 0xFFE0_0000.
- R3: `res_target` encodes 0 as unmapped, 1 as DDR and 2 as on-chip RAM. The DDR offset equals the address. The on-chip RAM offset is quarter×64 kB plus the low 16 address bits, and it is always below 256 kB. The unmapped offset is 0.
- R4: Bit i of the placement register (select 0) puts quarter i at 0xFFFC_0000 + i×64 kB when set. An address in the high window whose quarter is not placed high is unmapped.
- R5: When bit i of the placement register is clear, quarter i sits at i×64 kB for both kinds of requester, and it hides the DDR at those addresses.
- R6: With default settings, 0x0000_0000 to 0x0007_FFFF is DDR for the processor but unmapped for a fabric port (`lk_is_fabric`=1). Fabric ports never receive DDR below 0x0008_0000.
- R7: With default settings, 0x000C_0000 to 0x000F_FFFF maps to the on-chip RAM quarter selected by address bits 17:16 for the processor. This alias applies only when that quarter is placed high, filtering is active and the address lies within [start, end). Fabric ports see DDR there.
- R8: While filtering is active, any address in the lowest 1 MB that lies below the filter start (select 2) is unmapped for both kinds of requester, unless a low quarter claims it. A start of 0x0010_0000 therefore unmaps the whole lowest megabyte.
- R9: Writes to the filter start (select 2) and filter end (select 3) registers discard address bits 19:0.
- R10: Filtering is active only when both bits of the snoop control register (select 1) are set: bit 0 enables the unit and bit 1 enables filtering. When it is inactive, neither the alias nor the start-based unmapping applies.
- R11: Addresses that no other rule claims are DDR below 0x4000_0000 and unmapped from there up to the high window.
- R12: A register write takes effect only for lookups presented in later cycles. A lookup in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 placement, 1 snoop control, 2 filter start, 3 filter end |
| cfg_data | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Lookup address |
| lk_is_fabric | input | 1 | 1 for a fabric port requester, 0 for the processor |
| res_valid | output | 1 | Result valid, one cycle after the lookup |
| res_target | output | 2 | Target code |
| res_offset | output | 32 | Offset inside the target |

## Verification
The bench targets the places where the two kinds of requester disagree.

- **Low 512 kB:** here the processor must get DDR and a fabric port nothing. A decoder that ignored the requester would hand DDR to the fabric port.
- **Alias window:** this window must reach on-chip RAM only for the processor. A design that forgot the requester check would send fabric accesses into the on-chip RAM.
- **Filter writes:** start and end values with bits set below 1 MB are written. A register that kept those bits would unmap or alias addresses it must not.
- **Same-cycle write:** a lookup is placed in the same cycle as a write. A design that decoded from the incoming write data would answer early.
- **Cleared quarters:** quarters are moved low and the high window is probed. A design that still decoded a cleared high quarter would return on-chip RAM instead of unmapped.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DDR  = 2'd1,
        TGT_OCM  = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        SEL_PLACE = 2'd0,
        SEL_SNOOP = 2'd1,
        SEL_START = 2'd2,
        SEL_END   = 2'd3
    } sel_e;

    typedef struct packed {
        logic              valid;
        tgt_e              tgt;
        logic [ADDR_W-1:0] ofs;
    } res_t;
endpackage

// File: rtl/mmd_cfg_regs.sv
module mmd_cfg_regs
    import mmd_pkg::*;
#(
    parameter int          NUM_QTR   = 4,
    parameter int          MB_BITS   = 20,
    parameter logic [31:0] END_RESET = 32'hFFE0_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [ADDR_W-1:0]  wr_data,
    output logic [NUM_QTR-1:0] place_o,
    output logic               filt_on_o,
    output logic [ADDR_W-1:0]  fstart_o,
    output logic [ADDR_W-1:0]  fend_o
);
    typedef struct packed {
        logic [NUM_QTR-1:0] place;
        logic [1:0]         snoop;
        logic [ADDR_W-1:0]  fstart;
        logic [ADDR_W-1:0]  fend;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [ADDR_W-1:0] gran_data;

    always_comb begin
        gran_data = {wr_data[ADDR_W-1:MB_BITS], {MB_BITS{1'b0}}};
        cfg_d     = cfg_q;
        if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_PLACE: cfg_d.place  = wr_data[NUM_QTR-1:0];
                SEL_SNOOP: cfg_d.snoop  = wr_data[1:0];
                SEL_START: cfg_d.fstart = gran_data;
                SEL_END:   cfg_d.fend   = gran_data;
                default:   cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.place  <= '1;
            cfg_q.snoop  <= 2'b11;
            cfg_q.fstart <= '0;
            cfg_q.fend   <= END_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign place_o   = cfg_q.place;
    assign filt_on_o = cfg_q.snoop[0] & cfg_q.snoop[1];
    assign fstart_o  = cfg_q.fstart;
    assign fend_o    = cfg_q.fend;
endmodule

// File: rtl/mmd_addr_decode.sv
module mmd_addr_decode
    import mmd_pkg::*;
#(
    parameter int          NUM_QTR   = 4,
    parameter int          QTR_BITS  = 16,
    parameter int          MB_BITS   = 20,
    parameter logic [31:0] DDR_SIZE  = 32'h4000_0000,
    parameter logic [31:0] FAB_HOLE  = 32'h0008_0000,
    parameter logic [31:0] ALIAS_LO  = 32'h000C_0000
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               fabric,
    input  logic [NUM_QTR-1:0] place,
    input  logic               filt_on,
    input  logic [ADDR_W-1:0]  fstart,
    input  logic [ADDR_W-1:0]  fend,
    output tgt_e               tgt,
    output logic [ADDR_W-1:0]  ofs
);
    localparam int QSEL_W   = (NUM_QTR > 1) ? $clog2(NUM_QTR) : 1;
    localparam int OCM_BITS = QTR_BITS + QSEL_W;

    logic [QSEL_W-1:0]       qsel;
    logic [NUM_QTR-1:0]      lo_hit;
    logic [NUM_QTR-1:0]      hi_hit;
    logic                    low_win, high_win, low_mb;
    logic [ADDR_W-1:0]       ocm_ofs;

    assign qsel     = addr[OCM_BITS-1:QTR_BITS];
    assign low_win  = (addr[ADDR_W-1:OCM_BITS] == '0);
    assign high_win = (addr[ADDR_W-1:OCM_BITS] == '1);
    assign low_mb   = (addr[ADDR_W-1:MB_BITS] == '0);
    assign ocm_ofs  = {{(ADDR_W-OCM_BITS){1'b0}}, addr[OCM_BITS-1:0]};

    for (genvar i = 0; i < NUM_QTR; i++) begin : g_qtr
        assign lo_hit[i] = low_win  && (qsel == QSEL_W'(i)) && !place[i];
        assign hi_hit[i] = high_win && (qsel == QSEL_W'(i)) &&  place[i];
    end

    always_comb begin
        tgt = TGT_NONE;
        ofs = '0;
        if (|lo_hit) begin
            tgt = TGT_OCM;
            ofs = ocm_ofs;
        end else if (filt_on && low_mb && (addr < fstart)) begin
            tgt = TGT_NONE;
        end else if (!fabric && filt_on && low_mb && (addr >= ALIAS_LO)
                     && (addr < fend) && place[qsel]) begin
            tgt = TGT_OCM;
            ofs = ocm_ofs;
        end else if (fabric && (addr < FAB_HOLE)) begin
            tgt = TGT_NONE;
        end else if (addr < DDR_SIZE) begin
            tgt = TGT_DDR;
            ofs = addr;
        end else if (|hi_hit) begin
            tgt = TGT_OCM;
            ofs = ocm_ofs;
        end
    end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mmd_pkg::*;
#(
    parameter int          NUM_QTR  = 4,
    parameter int          QTR_BITS = 16,
    parameter int          MB_BITS  = 20,
    parameter logic [31:0] DDR_SIZE = 32'h4000_0000,
    parameter logic [31:0] FAB_HOLE = 32'h0008_0000,
    parameter logic [31:0] ALIAS_LO = 32'h000C_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_data,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    input  logic        lk_is_fabric,
    output logic        res_valid,
    output logic [1:0]  res_target,
    output logic [31:0] res_offset
);
    localparam logic [31:0] OCM_SIZE  = 32'(NUM_QTR) << QTR_BITS;
    localparam logic [31:0] HIGH_BASE = 32'h0 - OCM_SIZE;

    logic [NUM_QTR-1:0] place;
    logic               filt_on;
    logic [31:0]        fstart, fend;
    tgt_e               dec_tgt;
    logic [31:0]        dec_ofs;
    res_t               res_d, res_q;

    mmd_cfg_regs #(.NUM_QTR(NUM_QTR), .MB_BITS(MB_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_sel(cfg_sel),
        .wr_data(cfg_data), .place_o(place), .filt_on_o(filt_on),
        .fstart_o(fstart), .fend_o(fend)
    );

    mmd_addr_decode #(
        .NUM_QTR(NUM_QTR), .QTR_BITS(QTR_BITS), .MB_BITS(MB_BITS),
        .DDR_SIZE(DDR_SIZE), .FAB_HOLE(FAB_HOLE), .ALIAS_LO(ALIAS_LO)
    ) u_dec (
        .addr(lk_addr), .fabric(lk_is_fabric), .place(place),
        .filt_on(filt_on), .fstart(fstart), .fend(fend),
        .tgt(dec_tgt), .ofs(dec_ofs)
    );

    always_comb begin
        res_d.valid = lk_valid;
        res_d.tgt   = lk_valid ? dec_tgt : TGT_NONE;
        res_d.ofs   = lk_valid ? dec_ofs : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.valid;
    assign res_target = res_q.tgt;
    assign res_offset = res_q.ofs;

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R1
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R1
    AST_OCM_OFS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_target == TGT_OCM) |-> (res_offset < OCM_SIZE)); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_target == TGT_NONE) |-> (res_offset == '0)); // R3
    AST_FABRIC_LOW_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_is_fabric && lk_addr < FAB_HOLE) |=> (res_target != TGT_DDR)); // R6
    AST_GAP_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_addr >= DDR_SIZE && lk_addr < HIGH_BASE) |=> (res_target == TGT_NONE)); // R11
endmodule

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_is_fabric = 1'b0;
    logic        res_valid;
    logic [1:0]  res_target;
    logic [31:0] res_offset;

    int tests = 0;
    int fails = 0;

    // reference configuration state
    logic [3:0]  m_place = 4'hF;
    logic [1:0]  m_snoop = 2'b11;
    logic [31:0] m_start = 32'h0;
    logic [31:0] m_end   = 32'hFFE0_0000;

    always #2 clk = ~clk;

    mem_map_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_is_fabric(lk_is_fabric), .res_valid(res_valid),
        .res_target(res_target), .res_offset(res_offset)
    );

    // behavioural memory map: returns {target, offset}
    function automatic logic [33:0] ref_map(input logic [31:0] a, input logic fab);
        bit          filt = (m_snoop == 2'b11);
        int unsigned q    = a[17:16];
        logic [31:0] oo   = {14'd0, a[17:0]};
        if (a < 32'h0004_0000 && !m_place[q])                return {2'd2, oo};
        if (filt && a < 32'h0010_0000 && a < m_start)        return {2'd0, 32'd0};
        if (!fab && filt && a >= 32'h000C_0000 && a < 32'h0010_0000 &&
            a >= m_start && a < m_end && m_place[q])         return {2'd2, oo};
        if (fab && a < 32'h0008_0000)                        return {2'd0, 32'd0};
        if (a < 32'h4000_0000)                               return {2'd1, a};
        if (a >= 32'hFFFC_0000 && m_place[q])                return {2'd2, oo};
        return {2'd0, 32'd0};
    endfunction

    task automatic step(input bit wr, input logic [1:0] sel, input logic [31:0] d,
                        input bit v, input logic [31:0] a, input bit fab,
                        input string req);
        logic [33:0] exp;
        @(negedge clk);
        cfg_wr = wr; cfg_sel = sel; cfg_data = d;
        lk_valid = v; lk_addr = a; lk_is_fabric = fab;
        exp = v ? ref_map(a, fab) : 34'd0;
        if (wr) begin
            case (sel)
                2'd0: m_place = d[3:0];
                2'd1: m_snoop = d[1:0];
                2'd2: m_start = {d[31:20], 20'd0};
                default: m_end = {d[31:20], 20'd0};
            endcase
        end
        @(posedge clk);
        #1;
        tests++;
        if (res_valid !== v || res_target !== exp[33:32] || res_offset !== exp[31:0]) begin
            fails++;
            $display("FAIL %s addr=%h fab=%0d: got v=%0d t=%0d o=%h expected v=%0d t=%0d o=%h",
                     req, a, fab, res_valid, res_target, res_offset, v, exp[33:32], exp[31:0]);
        end
    endtask

    task automatic look(input logic [31:0] a, input bit fab, input string req);
        step(1'b0, 2'd0, 32'd0, 1'b1, a, fab, req);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string req);
        step(1'b1, sel, d, 1'b0, 32'd0, 1'b0, req);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tests++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got res_valid=%0d expected 0", res_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R6: default low region
        look(32'h0000_0000, 1'b0, "R6 proc low DDR");
        look(32'h0000_0000, 1'b1, "R6 fabric low unmapped");
        look(32'h0007_FFFC, 1'b1, "R6 fabric hole top");
        look(32'h0008_0000, 1'b1, "R6 fabric past hole");
        // R7 alias
        look(32'h000C_0000, 1'b0, "R7 proc alias");
        look(32'h000F_FFF0, 1'b0, "R7 proc alias top");
        look(32'h000C_0004, 1'b1, "R7 fabric DDR");
        // R4 R2 high window
        look(32'hFFFC_0010, 1'b0, "R4 high q0");
        look(32'hFFFF_0000, 1'b1, "R4 high q3");
        // R11 R3
        look(32'h3FFF_FFFC, 1'b0, "R11 DDR top");
        look(32'h4000_0000, 1'b0, "R11 gap");
        look(32'hF000_0000, 1'b1, "R11 gap fabric");
        // R1 idle
        step(1'b0, 2'd0, 32'd0, 1'b0, 32'h0, 1'b0, "R1 idle");

        // R9: sub-MB bits dropped from start
        wr(2'd2, 32'h000F_FFFF, "R9 write start");
        look(32'h0000_0000, 1'b0, "R9 start masked");
        // R12 + R8: write start, lookup same cycle
        step(1'b1, 2'd2, 32'h0010_0000, 1'b1, 32'h0000_0000, 1'b0, "R12 same cycle");
        look(32'h0000_0000, 1'b0, "R8 proc low unmapped");
        look(32'h0009_0000, 1'b1, "R8 fabric low unmapped");
        look(32'h000C_0000, 1'b0, "R8 alias gone");
        look(32'h0010_0000, 1'b1, "R8 above MB");
        // R10 filtering disabled
        wr(2'd1, 32'h0000_0001, "R10 snoop ctl");
        look(32'h0000_0000, 1'b0, "R10 proc DDR");
        look(32'h000C_0000, 1'b0, "R10 no alias");
        look(32'h0009_0000, 1'b1, "R10 fabric DDR");
        wr(2'd1, 32'h0000_0002, "R10 snoop ctl");
        look(32'h000D_0000, 1'b0, "R10 unit off");
        wr(2'd1, 32'h0000_0003, "R10 restore");
        // R9 end masked
        wr(2'd2, 32'h0000_0000, "R9 start zero");
        wr(2'd3, 32'h000C_FFFF, "R9 write end");
        look(32'h000C_0000, 1'b0, "R9 end masked no alias");
        wr(2'd3, 32'hFFE0_0000, "R9 restore end");
        look(32'h000E_0000, 1'b0, "R7 alias back");
        // R5 low quarters
        wr(2'd0, 32'h0000_000C, "R5 place");
        look(32'h0001_0004, 1'b0, "R5 proc low OCM");
        look(32'h0000_0000, 1'b1, "R5 fabric low OCM");
        look(32'hFFFC_0000, 1'b0, "R4 cleared quarter");
        look(32'hFFFE_0000, 1'b0, "R4 kept quarter");
        look(32'h0002_0000, 1'b0, "R5 q2 still DDR");
        wr(2'd0, 32'h0000_0000, "R5 all low");
        look(32'h0003_FFFC, 1'b1, "R5 q3 low");
        look(32'h000C_0000, 1'b0, "R7 alias needs high quarter");
        look(32'hFFFF_FFFC, 1'b0, "R4 all low high unmapped");

        // sweep mixed
        for (int i = 0; i < 64; i++) begin
            wr(2'd0, 32'(i % 16), "R4 sweep place");
            look(32'h0000_4000 + 32'(i) * 32'h0000_4000, i[0], "R5 sweep low");
            look(32'hFFFC_0000 + 32'(i) * 32'h0000_1000, i[1], "R4 sweep high");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule